// File: doc/BRIEF.md
# USB Bulk/Interrupt Transfer Packetizer

This block sits beside a USB device endpoint that serves bulk or interrupt traffic. Firmware primes it once with a transfer descriptor: a total byte count, the endpoint's maximum packet size and a flag that turns the trailing empty packet off. The block then works out the length of each packet in the transfer. For every host token it answers with a handshake decision. It counts the remaining bytes down as packets are acknowledged.

Until a descriptor has been loaded, every token is refused with a NAK. Once loaded, each token gets a data decision and the length of the packet currently due. A failed packet is retried at the same length, because only an acknowledge moves the transfer forward. When the last packet is acknowledged, the descriptor retires with a one-cycle completion pulse and the endpoint drops back to refusing tokens. Bulk and interrupt endpoints are treated exactly alike. The endpoint type is not an input.

Top module: `td_packetizer`

## Requirements
- R1: After synchronous reset the endpoint is unprimed and `hs_o` = 2'b00, `done_o` = 0, `bytes_left_o` = 0, `pkt_idx_o` = 0.
- R2: A token while unprimed yields `hs_o` = 2'b01 (NAK) with `pkt_len_o` = 0 on the cycle after the token. In every cycle without a token, `hs_o` = 2'b00.
- R3: A prime while unprimed loads the descriptor, so that `bytes_left_o` shows the total on the next cycle. A token while primed then yields `hs_o` = 2'b10 (DATA) on the cycle after it, with `pkt_len_o` equal to the current packet's length.
- R4: With the termination bit low, a total B at maximum size M gives floor(B/M)+1 packets. All packets but the last carry M bytes and the last carries B mod M bytes, which may be 0 (512/256 gives 256,256,0).
- R5: With the termination bit high, B > 0 gives ceil(B/M) packets. All packets but the last carry M bytes and no empty packet follows (512/256 gives 256,256; 511/256 gives 256,255).
- R6: A zero-byte descriptor produces exactly one zero-length packet under either setting of the termination bit.
- R7: Only `ack_i` while primed reduces `bytes_left_o` by the packet length and steps `pkt_idx_o`, the 0-based index of the packet due. A token that is not acknowledged is answered again with the same length.
- R8: An acknowledge of the last packet gives `done_o` = 1 for exactly one cycle, on the cycle after the acknowledge, with `bytes_left_o` = 0 at that time. From then on, tokens are answered with NAK.
- R9: A prime while primed is ignored. The descriptor in progress, its remaining count and its packet lengths are unchanged.
- R10: An acknowledge while unprimed is ignored. No completion pulse follows and `bytes_left_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prime_i | input | 1 | Load the descriptor presented on the fields below |
| td_bytes_i | input | 12 | Total byte count of the descriptor |
| mps_i | input | 11 | Maximum packet size, nonzero |
| zlt_off_i | input | 1 | 1 disables the trailing zero-length packet |
| token_i | input | 1 | Host IN/OUT token strobe |
| ack_i | input | 1 | Current packet completed successfully |
| hs_o | output | 2 | Handshake decision: 00 none, 01 NAK, 10 DATA |
| pkt_len_o | output | 12 | Length of the packet answered with DATA |
| done_o | output | 1 | One-cycle descriptor retirement pulse |
| bytes_left_o | output | 12 | Bytes not yet acknowledged |
| pkt_idx_o | output | 13 | Index of the packet now due |

## Verification
A corrupted remaining count or latched packet size shows up in `pkt_len_o` on the very next token. It also shows up in `bytes_left_o` one cycle after the next acknowledge. A wrong final-packet decision appears as a completion pulse that comes one packet early or late, or never comes. A wrong decision is easiest to see at exact multiples of the packet size, where the two termination settings differ by one empty packet. A stuck primed state is visible as a DATA answer where a NAK is due, on the cycle after the first token following retirement.

// File: rtl/td_pkt_pkg.sv
package td_pkt_pkg;

    localparam int TD_BYTES_W = 12;
    localparam int TD_MPS_W   = 11;
    localparam int TD_IDX_W   = TD_BYTES_W + 1;

    typedef enum logic [1:0] {
        HS_NONE = 2'b00,
        HS_NAK  = 2'b01,
        HS_DATA = 2'b10
    } hs_e;

    typedef struct packed {
        logic                  active;
        logic                  zlt_off;
        logic [TD_MPS_W-1:0]   mps;
        logic [TD_BYTES_W-1:0] remain;
    } td_ctx_t;

    function automatic logic [TD_BYTES_W-1:0] widen_mps(input logic [TD_MPS_W-1:0] m);
        return {{(TD_BYTES_W-TD_MPS_W){1'b0}}, m};
    endfunction

endpackage

// File: rtl/td_len_calc.sv
module td_len_calc
    import td_pkt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  td_ctx_t               ctx,
    output logic [TD_BYTES_W-1:0] cur_len,
    output logic                  final_pkt
);
    logic [TD_BYTES_W-1:0] mps_w;

    always_comb begin
        mps_w     = widen_mps(ctx.mps);
        cur_len   = (ctx.remain < mps_w) ? ctx.remain : mps_w;
        // Termination on: a short packet (possibly empty) ends the transfer.
        // Termination off: the packet that empties the count ends it.
        final_pkt = ctx.zlt_off ? (ctx.remain <= mps_w) : (ctx.remain < mps_w);
    end

    // R5: with termination off, no empty packet while bytes remain
    a_r5_no_empty_tail: assert property (@(posedge clk) disable iff (rst)
        (ctx.active && ctx.zlt_off && ctx.remain != '0) |-> (cur_len != '0));

    // R4: a packet never exceeds the latched maximum size
    a_r4_len_bound: assert property (@(posedge clk) disable iff (rst)
        ctx.active |-> (cur_len <= mps_w));

endmodule

// File: rtl/td_ctrl.sv
module td_ctrl
    import td_pkt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  prime_i,
    input  logic [TD_BYTES_W-1:0] td_bytes_i,
    input  logic [TD_MPS_W-1:0]   mps_i,
    input  logic                  zlt_off_i,
    input  logic                  ack_i,
    input  logic [TD_BYTES_W-1:0] cur_len,
    input  logic                  final_pkt,
    output td_ctx_t               ctx,
    output logic [TD_IDX_W-1:0]   idx,
    output logic                  done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx  <= '0;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!ctx.active) begin
                if (prime_i) begin
                    ctx.active  <= 1'b1;
                    ctx.zlt_off <= zlt_off_i;
                    ctx.mps     <= mps_i;
                    ctx.remain  <= td_bytes_i;
                    idx         <= '0;
                end
            end else if (ack_i) begin
                ctx.remain <= ctx.remain - cur_len;
                if (final_pkt) begin
                    ctx.active <= 1'b0;
                    idx        <= '0;
                    done       <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    a_r8_done_zero: assert property (@(posedge clk) disable iff (rst)
        done |-> (ctx.remain == '0 && !ctx.active));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_prime_ignored: assert property (@(posedge clk) disable iff (rst)
        (ctx.active && prime_i && !ack_i) |=> ($stable(ctx.remain) && $stable(ctx.mps) && $stable(ctx.zlt_off)));

    a_r7_hold_without_ack: assert property (@(posedge clk) disable iff (rst)
        (ctx.active && !ack_i) |=> ($stable(ctx.remain) && $stable(idx) && ctx.active));

    a_r10_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (!ctx.active && !prime_i) |=> (!ctx.active && !done));

endmodule

// File: rtl/td_resp.sv
module td_resp
    import td_pkt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  token_i,
    input  logic                  active,
    input  logic [TD_BYTES_W-1:0] cur_len,
    output hs_e                   hs,
    output logic [TD_BYTES_W-1:0] len
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hs  <= HS_NONE;
            len <= '0;
        end else if (token_i) begin
            hs  <= active ? HS_DATA : HS_NAK;
            len <= active ? cur_len : '0;
        end else begin
            hs  <= HS_NONE;
            len <= '0;
        end
    end

    a_r2_nak_unprimed: assert property (@(posedge clk) disable iff (rst)
        (token_i && !active) |=> (hs == HS_NAK && len == '0));

    a_r3_data_primed: assert property (@(posedge clk) disable iff (rst)
        (token_i && active) |=> (hs == HS_DATA));

    a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
        !token_i |=> (hs == HS_NONE));

endmodule

// File: rtl/td_packetizer.sv
module td_packetizer
    import td_pkt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  prime_i,
    input  logic [TD_BYTES_W-1:0] td_bytes_i,
    input  logic [TD_MPS_W-1:0]   mps_i,
    input  logic                  zlt_off_i,
    input  logic                  token_i,
    input  logic                  ack_i,
    output logic [1:0]            hs_o,
    output logic [TD_BYTES_W-1:0] pkt_len_o,
    output logic                  done_o,
    output logic [TD_BYTES_W-1:0] bytes_left_o,
    output logic [TD_IDX_W-1:0]   pkt_idx_o
);
    td_ctx_t               ctx;
    logic [TD_BYTES_W-1:0] cur_len;
    logic                  final_pkt;
    hs_e                   hs;

    td_len_calc u_len (
        .clk       (clk),
        .rst       (rst),
        .ctx       (ctx),
        .cur_len   (cur_len),
        .final_pkt (final_pkt)
    );

    td_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .prime_i    (prime_i),
        .td_bytes_i (td_bytes_i),
        .mps_i      (mps_i),
        .zlt_off_i  (zlt_off_i),
        .ack_i      (ack_i),
        .cur_len    (cur_len),
        .final_pkt  (final_pkt),
        .ctx        (ctx),
        .idx        (pkt_idx_o),
        .done       (done_o)
    );

    td_resp u_resp (
        .clk     (clk),
        .rst     (rst),
        .token_i (token_i),
        .active  (ctx.active),
        .cur_len (cur_len),
        .hs      (hs),
        .len     (pkt_len_o)
    );

    assign hs_o         = hs;
    assign bytes_left_o = ctx.remain;

endmodule

// File: tb/td_packetizer_tb.sv
`timescale 1ns/1ps
module td_packetizer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prime_i = 1'b0;
    logic [11:0] td_bytes_i = '0;
    logic [10:0] mps_i = 11'd1;
    logic        zlt_off_i = 1'b0;
    logic        token_i = 1'b0;
    logic        ack_i = 1'b0;
    logic [1:0]  hs_o;
    logic [11:0] pkt_len_o;
    logic        done_o;
    logic [11:0] bytes_left_o;
    logic [12:0] pkt_idx_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    td_packetizer u_dut (
        .clk(clk), .rst(rst), .prime_i(prime_i), .td_bytes_i(td_bytes_i),
        .mps_i(mps_i), .zlt_off_i(zlt_off_i), .token_i(token_i), .ack_i(ack_i),
        .hs_o(hs_o), .pkt_len_o(pkt_len_o), .done_o(done_o),
        .bytes_left_o(bytes_left_o), .pkt_idx_o(pkt_idx_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tok();
        token_i = 1'b1;
        @(negedge clk);
        token_i = 1'b0;
    endtask

    task automatic ackp();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic run_xfer(input int b, input int m, input bit zoff, input bit poke);
        int n;
        string rq;
        if (b == 0) n = 1;
        else if (zoff) n = (b + m - 1) / m;
        else n = b / m + 1;
        rq = (b == 0) ? "R6" : (zoff ? "R5" : "R4");
        td_bytes_i = 12'(b); mps_i = 11'(m); zlt_off_i = zoff;
        prime_i = 1'b1;
        @(negedge clk);
        prime_i = 1'b0;
        chk(int'(bytes_left_o) == b, "R3 bytes_left", int'(bytes_left_o), b);
        for (int k = 0; k < n; k++) begin
            int exp_len;
            exp_len = (k < n - 1) ? m : b - (n - 1) * m;
            tok();
            chk(hs_o == 2'b10, "R3 hs", int'(hs_o), 2);
            chk(int'(pkt_len_o) == exp_len, rq, int'(pkt_len_o), exp_len);
            chk(int'(pkt_idx_o) == k, "R7 idx", int'(pkt_idx_o), k);
            if (poke && k == 0) begin
                td_bytes_i = 12'(b + 7); mps_i = 11'(m + 1); zlt_off_i = ~zoff;
                prime_i = 1'b1;
                @(negedge clk);
                prime_i = 1'b0;
                chk(int'(bytes_left_o) == b, "R9 bytes_left", int'(bytes_left_o), b);
                tok();
                chk(int'(pkt_len_o) == exp_len, "R9 len", int'(pkt_len_o), exp_len);
                chk(int'(pkt_len_o) == exp_len, "R7 retry len", int'(pkt_len_o), exp_len);
            end
            ackp();
            if (k == n - 1) begin
                chk(done_o == 1'b1, "R8 done", int'(done_o), 1);
                chk(bytes_left_o == '0, "R8 zero", int'(bytes_left_o), 0);
            end else begin
                chk(done_o == 1'b0, "R8 early done", int'(done_o), 0);
                chk(int'(bytes_left_o) == b - (k + 1) * m, "R7 bytes_left",
                    int'(bytes_left_o), b - (k + 1) * m);
            end
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R8 pulse width", int'(done_o), 0);
        tok();
        chk(hs_o == 2'b01, "R8 nak after retire", int'(hs_o), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(hs_o == 2'b00, "R1 hs", int'(hs_o), 0);
        chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
        chk(bytes_left_o == '0, "R1 bytes_left", int'(bytes_left_o), 0);
        chk(pkt_idx_o == '0, "R1 idx", int'(pkt_idx_o), 0);
        // R2: unprimed tokens are refused, quiet otherwise
        tok();
        chk(hs_o == 2'b01, "R2 nak", int'(hs_o), 1);
        chk(pkt_len_o == '0, "R2 len", int'(pkt_len_o), 0);
        @(negedge clk);
        chk(hs_o == 2'b00, "R2 quiet", int'(hs_o), 0);
        // R10: stray acknowledge while unprimed
        ackp();
        chk(done_o == 1'b0, "R10 done", int'(done_o), 0);
        chk(bytes_left_o == '0, "R10 bytes_left", int'(bytes_left_o), 0);
        tok();
        chk(hs_o == 2'b01, "R10 nak", int'(hs_o), 1);
        // Worked examples from R4 and R5
        run_xfer(511, 256, 1'b0, 1'b0);
        run_xfer(511, 256, 1'b1, 1'b0);
        run_xfer(512, 256, 1'b0, 1'b0);
        run_xfer(512, 256, 1'b1, 1'b0);
        run_xfer(512, 512, 1'b0, 1'b0);
        run_xfer(512, 512, 1'b1, 1'b0);
        // Sweep over small sizes, both termination settings
        for (int zo = 0; zo < 2; zo++) begin
            for (int mi = 0; mi < 4; mi++) begin
                int m;
                m = (mi == 0) ? 1 : (mi == 1) ? 4 : (mi == 2) ? 8 : 13;
                for (int b = 0; b <= 40; b++) begin
                    run_xfer(b, m, zo[0], (b % 5) == 2);
                end
            end
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule